// File: doc/BRIEF.md
# Serial-to-Bus Command Bridge

This block lets a host that only has an SPI port drive a Wishbone classic bus. The host runs one frame per bus access. The frame starts with a command byte and an address byte. For a write, four data bytes follow. The bridge then starts a single Wishbone transfer. While the transfer waits for `ack`, every byte the host clocks is answered with 0xFF. The first byte answered after the acknowledge is 0x00. For a read, the word that was fetched then follows, most significant byte first.

The serial side works entirely on the SPI clock. It assembles received bytes and launches reply bytes. The decoder, the bus master and the reply selection work on the system clock. Each received byte crosses into the system domain through a toggle handshake, and the value of the toggle qualifies the byte register. The reply byte comes back as a register that the decoder changes only just after a byte boundary. The serial side loads it on the falling edge that follows the boundary. For this to work, half an SPI clock period must last longer than about five system clock cycles.

Top module: `spiwb_bridge`

## Requirements
- R1: Command byte bit 7 is the write flag (1 = write) and bits 3:0 are the byte-lane selects, driven on `wb_sel_o`. Bits 6:4 are ignored. The second byte of the frame is driven on `wb_adr_o`.
- R2: For a write, the four bytes after the address form `wb_dat_o`, first byte in bits 31:24. The transfer is issued with `wb_we_o` high.
- R3: From the first byte after the command has been fully received until the acknowledge is reported, each byte the host clocks returns 0xFF. There is at least one such byte. A slow bus gives more of them.
- R4: The first byte answered after the bus acknowledges returns 0x00.
- R5: For a read (bit 7 = 0), the 0x00 byte is followed by the four bytes of read data, most significant byte first. The data is the value on `wb_dat_i` in the cycle `wb_ack_i` is high.
- R6: The command byte, the address byte and write data bytes are answered with 0x00 on `spi_sdo`.
- R7: `wb_cyc_o` and `wb_stb_o` are always equal. Once raised, they stay high with stable address, data, select and write flag until `wb_ack_i`. They drop in the cycle after `wb_ack_i`. Each frame produces exactly one transfer.
- R8: Raising `spi_cs_n` aborts the frame. A partly shifted byte is discarded, the decoder returns to expecting a command byte, and a frame aborted before its command is complete issues no bus transfer.
- R9: SPI mode 0, MSB first. `spi_sdi` is sampled on rising `spi_sck` and `spi_sdo` changes on falling `spi_sck`. At reset `wb_stb_o`/`wb_cyc_o` are low and `spi_sdo` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System (bus) clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | SPI serial clock from the host |
| spi_cs_n | input | 1 | Active-low frame select |
| spi_sdi | input | 1 | Serial data from the host |
| spi_sdo | output | 1 | Serial data to the host |
| wb_adr_o | output | 8 | Bus address |
| wb_dat_o | output | 32 | Bus write data |
| wb_sel_o | output | 4 | Byte-lane selects |
| wb_we_o | output | 1 | Write enable |
| wb_stb_o | output | 1 | Strobe |
| wb_cyc_o | output | 1 | Cycle valid |
| wb_dat_i | input | 32 | Bus read data |
| wb_ack_i | input | 1 | Bus acknowledge |

## Verification
Full writes, partial-lane writes and reads are run against a bus slave whose acknowledge latency can be set. Running the same command with a zero-cycle latency and with a latency of several byte times shows whether the count of 0xFF bytes follows the bus and whether the 0x00 marker arrives exactly once. Writes to two different addresses, read back afterwards, show that the address, the byte order and the lane masking are right. Frames aborted after the address, in mid-data and in mid-byte, each followed by a clean read, show that an abort leaves no transfer and no stale decoder state behind.

// File: rtl/spiwb_pkg.sv
package spiwb_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        DS_CMD,
        DS_ADR,
        DS_WDAT,
        DS_BUS,
        DS_ACKD,
        DS_RDAT
    } dec_state_e;

    localparam logic [BYTE_W-1:0] REPLY_WAIT  = 8'hFF;
    localparam logic [BYTE_W-1:0] REPLY_READY = 8'h00;
    localparam logic [BYTE_W-1:0] REPLY_FILL  = 8'h00;

endpackage

// File: rtl/spiwb_sync.sv
module spiwb_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], d_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= chain_d;
    end

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/spiwb_shifter.sv
module spiwb_shifter
    import spiwb_pkg::*;
(
    input  logic              sck,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sdi,
    input  logic [BYTE_W-1:0] reply_i,
    output logic              sdo,
    output logic [BYTE_W-1:0] rx_byte_o,
    output logic              rx_tog_o
);

    localparam int CNT_W = $clog2(BYTE_W);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-2:0] sh;
    } rx_t;

    typedef struct packed {
        logic [BYTE_W-1:0] byte_v;
        logic              tog;
    } out_t;

    rx_t               rx_d, rx_q;
    out_t              out_d, out_q;
    logic [BYTE_W-1:0] tx_d, tx_q;
    logic              frame_rst;
    logic              byte_end;

    // Frame-local state clears whenever the frame is deselected.
    assign frame_rst = cs_n | ~rst_n;
    assign byte_end  = (rx_q.cnt == CNT_W'(BYTE_W - 1));

    always_comb begin
        rx_d     = rx_q;
        rx_d.cnt = rx_q.cnt + 1'b1;
        rx_d.sh  = {rx_q.sh[BYTE_W-3:0], sdi};
    end

    always_ff @(posedge sck or posedge frame_rst) begin
        if (frame_rst) rx_q <= '0;
        else           rx_q <= rx_d;
    end

    // Completed byte and its toggle survive deselect, so no false event crosses over.
    always_comb begin
        out_d = out_q;
        if (byte_end) begin
            out_d.byte_v = {rx_q.sh, sdi};
            out_d.tog    = ~out_q.tog;
        end
    end

    always_ff @(posedge sck or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    // Reply launch on the falling edge: load at byte boundary, otherwise shift.
    always_comb begin
        if (rx_q.cnt == '0) tx_d = reply_i;
        else                tx_d = {tx_q[BYTE_W-2:0], 1'b0};
    end

    always_ff @(negedge sck or posedge frame_rst) begin
        if (frame_rst) tx_q <= REPLY_FILL;
        else           tx_q <= tx_d;
    end

    assign sdo       = tx_q[BYTE_W-1];
    assign rx_byte_o = out_q.byte_v;
    assign rx_tog_o  = out_q.tog;

endmodule

// File: rtl/spiwb_decoder.sv
module spiwb_decoder
    import spiwb_pkg::*;
#(
    parameter int ADR_W = 8,
    parameter int DAT_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               byte_tog_i,
    input  logic               cs_idle_i,
    input  logic [BYTE_W-1:0]  rx_byte_i,
    output logic [BYTE_W-1:0]  reply_o,
    output logic [ADR_W-1:0]   wb_adr_o,
    output logic [DAT_W-1:0]   wb_dat_o,
    output logic [DAT_W/8-1:0] wb_sel_o,
    output logic               wb_we_o,
    output logic               wb_stb_o,
    output logic               wb_cyc_o,
    input  logic [DAT_W-1:0]   wb_dat_i,
    input  logic               wb_ack_i
);

    localparam int SEL_W = DAT_W / 8;
    localparam int NB    = DAT_W / BYTE_W;
    localparam int IDX_W = (NB > 1) ? $clog2(NB) : 1;
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NB - 1);

    typedef struct packed {
        dec_state_e        state;
        logic              tog;
        logic              we;
        logic [SEL_W-1:0]  sel;
        logic [ADR_W-1:0]  adr;
        logic [DAT_W-1:0]  wdat;
        logic [DAT_W-1:0]  rdat;
        logic [IDX_W-1:0]  idx;
        logic              stb;
        logic              acked;
        logic [BYTE_W-1:0] reply;
    } dec_t;

    dec_t dec_d, dec_q;
    logic byte_evt;

    assign byte_evt = byte_tog_i ^ dec_q.tog;

    always_comb begin
        dec_d     = dec_q;
        dec_d.tog = byte_tog_i;

        if (dec_q.stb && wb_ack_i) begin
            dec_d.stb   = 1'b0;
            dec_d.acked = 1'b1;
            dec_d.rdat  = wb_dat_i;
        end

        if (cs_idle_i) begin
            // A transfer in flight is finished before returning to command state.
            if (!dec_d.stb) begin
                dec_d.state = DS_CMD;
                dec_d.reply = REPLY_FILL;
                dec_d.idx   = '0;
            end
        end else if (byte_evt) begin
            unique case (dec_q.state)
                DS_CMD: begin
                    dec_d.we    = rx_byte_i[7];
                    dec_d.sel   = rx_byte_i[SEL_W-1:0];
                    dec_d.state = DS_ADR;
                end
                DS_ADR: begin
                    dec_d.adr = rx_byte_i[ADR_W-1:0];
                    dec_d.idx = '0;
                    if (dec_q.we) begin
                        dec_d.state = DS_WDAT;
                    end else begin
                        dec_d.stb   = 1'b1;
                        dec_d.acked = 1'b0;
                        dec_d.reply = REPLY_WAIT;
                        dec_d.state = DS_BUS;
                    end
                end
                DS_WDAT: begin
                    dec_d.wdat = {dec_q.wdat[DAT_W-BYTE_W-1:0], rx_byte_i};
                    dec_d.idx  = dec_q.idx + 1'b1;
                    if (dec_q.idx == IDX_LAST) begin
                        dec_d.stb   = 1'b1;
                        dec_d.acked = 1'b0;
                        dec_d.reply = REPLY_WAIT;
                        dec_d.state = DS_BUS;
                    end
                end
                DS_BUS: begin
                    if (dec_q.acked) begin
                        dec_d.reply = REPLY_READY;
                        dec_d.state = DS_ACKD;
                    end else begin
                        dec_d.reply = REPLY_WAIT;
                    end
                end
                DS_ACKD: begin
                    if (dec_q.we) begin
                        dec_d.reply = REPLY_FILL;
                        dec_d.state = DS_CMD;
                    end else begin
                        dec_d.reply = dec_q.rdat[DAT_W-1 -: BYTE_W];
                        dec_d.rdat  = dec_q.rdat << BYTE_W;
                        dec_d.idx   = '0;
                        dec_d.state = DS_RDAT;
                    end
                end
                DS_RDAT: begin
                    if (dec_q.idx == IDX_LAST) begin
                        dec_d.reply = REPLY_FILL;
                        dec_d.state = DS_CMD;
                    end else begin
                        dec_d.reply = dec_q.rdat[DAT_W-1 -: BYTE_W];
                        dec_d.rdat  = dec_q.rdat << BYTE_W;
                        dec_d.idx   = dec_q.idx + 1'b1;
                    end
                end
                default: dec_d.state = DS_CMD;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dec_q       <= '0;
            dec_q.state <= DS_CMD;
            dec_q.reply <= REPLY_FILL;
        end else begin
            dec_q <= dec_d;
        end
    end

    assign reply_o  = dec_q.reply;
    assign wb_adr_o = dec_q.adr;
    assign wb_dat_o = dec_q.wdat;
    assign wb_sel_o = dec_q.sel;
    assign wb_we_o  = dec_q.we;
    assign wb_stb_o = dec_q.stb;
    assign wb_cyc_o = dec_q.stb;

    AST_CYC_FOLLOWS_STB: assert property (@(posedge clk) disable iff (!rst_n)
        wb_cyc_o == wb_stb_o); // R7

    AST_STB_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_stb_o && !wb_ack_i) |=> wb_stb_o); // R7

    AST_STB_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_stb_o && wb_ack_i) |=> !wb_stb_o); // R7

    AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_stb_o && !wb_ack_i) |=> ($stable(wb_adr_o) && $stable(wb_dat_o)
                                     && $stable(wb_sel_o) && $stable(wb_we_o))); // R7

    AST_WAIT_REPLY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wb_stb_o) |-> (reply_o == REPLY_WAIT)); // R3

endmodule

// File: rtl/spiwb_bridge.sv
module spiwb_bridge
    import spiwb_pkg::*;
#(
    parameter int ADR_W       = 8,
    parameter int DAT_W       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               spi_sck,
    input  logic               spi_cs_n,
    input  logic               spi_sdi,
    output logic               spi_sdo,
    output logic [ADR_W-1:0]   wb_adr_o,
    output logic [DAT_W-1:0]   wb_dat_o,
    output logic [DAT_W/8-1:0] wb_sel_o,
    output logic               wb_we_o,
    output logic               wb_stb_o,
    output logic               wb_cyc_o,
    input  logic [DAT_W-1:0]   wb_dat_i,
    input  logic               wb_ack_i
);

    logic [BYTE_W-1:0] rx_byte;
    logic [BYTE_W-1:0] reply;
    logic              rx_tog;
    logic              rx_tog_sync;
    logic              cs_idle_sync;

    spiwb_shifter u_shifter (
        .sck       (spi_sck),
        .rst_n     (rst_n),
        .cs_n      (spi_cs_n),
        .sdi       (spi_sdi),
        .reply_i   (reply),
        .sdo       (spi_sdo),
        .rx_byte_o (rx_byte),
        .rx_tog_o  (rx_tog)
    );

    spiwb_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_tog (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (rx_tog),
        .q_o   (rx_tog_sync)
    );

    spiwb_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_cs (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (spi_cs_n),
        .q_o   (cs_idle_sync)
    );

    spiwb_decoder #(.ADR_W(ADR_W), .DAT_W(DAT_W)) u_decoder (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_tog_i (rx_tog_sync),
        .cs_idle_i  (cs_idle_sync),
        .rx_byte_i  (rx_byte),
        .reply_o    (reply),
        .wb_adr_o   (wb_adr_o),
        .wb_dat_o   (wb_dat_o),
        .wb_sel_o   (wb_sel_o),
        .wb_we_o    (wb_we_o),
        .wb_stb_o   (wb_stb_o),
        .wb_cyc_o   (wb_cyc_o),
        .wb_dat_i   (wb_dat_i),
        .wb_ack_i   (wb_ack_i)
    );

endmodule

// File: tb/spiwb_bridge_tb.sv
`timescale 1ns/1ps
module spiwb_bridge_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        spi_sck = 1'b0;
    logic        spi_cs_n = 1'b1;
    logic        spi_sdi = 1'b0;
    logic        spi_sdo;
    logic [7:0]  wb_adr;
    logic [31:0] wb_dat_o;
    logic [3:0]  wb_sel;
    logic        wb_we, wb_stb, wb_cyc;
    logic [31:0] wb_dat_i;
    logic        wb_ack = 1'b0;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [31:0] mem [16];
    int          ack_delay = 0;
    int          dly_cnt = 0;
    int          txn_cnt = 0;
    logic [7:0]  last_adr;
    logic [3:0]  last_sel;
    logic        last_we;
    logic [31:0] last_wdat;

    localparam time HALF = 200;

    always #10 clk = ~clk;

    spiwb_bridge u_dut (
        .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
        .spi_sdi(spi_sdi), .spi_sdo(spi_sdo), .wb_adr_o(wb_adr), .wb_dat_o(wb_dat_o),
        .wb_sel_o(wb_sel), .wb_we_o(wb_we), .wb_stb_o(wb_stb), .wb_cyc_o(wb_cyc),
        .wb_dat_i(wb_dat_i), .wb_ack_i(wb_ack)
    );

    assign wb_dat_i = mem[wb_adr[3:0]];

    // Bus slave with programmable acknowledge latency.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) mem[i] <= 32'h0;
            wb_ack  <= 1'b0;
            dly_cnt <= 0;
        end else begin
            wb_ack <= 1'b0;
            if (wb_stb && wb_cyc && !wb_ack) begin
                if (dly_cnt >= ack_delay) begin
                    wb_ack    <= 1'b1;
                    dly_cnt   <= 0;
                    txn_cnt   <= txn_cnt + 1;
                    last_adr  <= wb_adr;
                    last_sel  <= wb_sel;
                    last_we   <= wb_we;
                    last_wdat <= wb_dat_o;
                    if (wb_we)
                        for (int b = 0; b < 4; b++)
                            if (wb_sel[b]) mem[wb_adr[3:0]][b*8 +: 8] <= wb_dat_o[b*8 +: 8];
                end else begin
                    dly_cnt <= dly_cnt + 1;
                end
            end
        end
    end

    task automatic check(input string req, input string what, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            spi_sdi = tx[i];
            #HALF;
            rx[i] = spi_sdo;
            spi_sck = 1'b1;
            #HALF;
            spi_sck = 1'b0;
        end
    endtask

    task automatic spi_bits(input int n);
        for (int i = 0; i < n; i++) begin
            spi_sdi = 1'b1;
            #HALF; spi_sck = 1'b1;
            #HALF; spi_sck = 1'b0;
        end
    endtask

    task automatic frame_begin();
        spi_cs_n = 1'b0;
        #HALF;
    endtask

    task automatic frame_end();
        #HALF;
        spi_cs_n = 1'b1;
        #1000;
    endtask

    // Clock filler bytes until the ready marker; returns number of wait bytes.
    task automatic wait_ready(input string req, output int nwait);
        logic [7:0] rx;
        bit seen = 0;
        nwait = 0;
        for (int k = 0; k < 40 && !seen; k++) begin
            spi_byte(8'h00, rx);
            if (rx == 8'hFF) nwait++;
            else begin
                seen = 1;
                check("R4", "ready marker", {24'h0, rx}, 32'h0);
            end
        end
        if (!seen) check(req, "ready marker never seen", 32'hFF, 32'h0);
    endtask

    task automatic do_write(input logic [7:0] cmd, input logic [7:0] adr,
                            input logic [31:0] data, input int delay, input int min_wait);
        logic [7:0] rx;
        int nwait;
        int t0 = txn_cnt;
        ack_delay = delay;
        frame_begin();
        spi_byte(cmd, rx);  check("R6", "reply to command byte", {24'h0, rx}, 32'h0);
        spi_byte(adr, rx);  check("R6", "reply to address byte", {24'h0, rx}, 32'h0);
        for (int b = 3; b >= 0; b--) begin
            spi_byte(data[b*8 +: 8], rx);
            check("R6", "reply to data byte", {24'h0, rx}, 32'h0);
        end
        wait_ready("R4", nwait);
        check("R3", "at least min wait bytes", 32'(nwait >= min_wait), 32'h1);
        frame_end();
        check("R7", "one transfer per write frame", 32'(txn_cnt - t0), 32'h1);
        check("R1", "write flag", {31'h0, last_we}, 32'h1);
        check("R1", "lane select", {28'h0, last_sel}, {28'h0, cmd[3:0]});
        check("R1", "address", {24'h0, last_adr}, {24'h0, adr});
        check("R2", "write data MSB first", last_wdat, data);
        check("R7", "strobe low after frame", {31'h0, wb_stb | wb_cyc}, 32'h0);
    endtask

    task automatic do_read(input logic [7:0] adr, input logic [31:0] exp, input int delay,
                           input int min_wait, input int max_wait);
        logic [7:0] rx;
        logic [31:0] got;
        int nwait;
        int t0 = txn_cnt;
        ack_delay = delay;
        frame_begin();
        spi_byte(8'h70, rx); check("R6", "reply to read command", {24'h0, rx}, 32'h0);
        spi_byte(adr, rx);   check("R6", "reply to read address", {24'h0, rx}, 32'h0);
        wait_ready("R4", nwait);
        check("R3", "wait bytes lower bound", 32'(nwait >= min_wait), 32'h1);
        check("R3", "wait bytes upper bound", 32'(nwait <= max_wait), 32'h1);
        for (int b = 3; b >= 0; b--) begin
            spi_byte(8'h00, rx);
            got[b*8 +: 8] = rx;
        end
        check("R5", "read data MSB first", got, exp);
        frame_end();
        check("R7", "one transfer per read frame", 32'(txn_cnt - t0), 32'h1);
        check("R1", "read flag clear", {31'h0, last_we}, 32'h0);
        check("R1", "read address", {24'h0, last_adr}, {24'h0, adr});
    endtask

    task automatic test_reset();
        check("R9", "sdo at reset", {31'h0, spi_sdo}, 32'h0);
        check("R9", "stb/cyc at reset", {30'h0, wb_stb, wb_cyc}, 32'h0);
    endtask

    task automatic test_write_read();
        do_write(8'h8F, 8'h05, 32'h12345678, 2, 1);
        do_read(8'h05, 32'h12345678, 0, 1, 1);
        // bits 6:4 set and partial lanes: only low two lanes change
        do_write(8'hF3, 8'h05, 32'hAABBCCDD, 0, 1);
        do_read(8'h05, 32'h1234CCDD, 0, 1, 1);
        do_write(8'h8F, 8'h0A, 32'hCAFE0001, 0, 1);
        do_read(8'h05, 32'h1234CCDD, 0, 1, 1);
    endtask

    task automatic test_slow_bus();
        // ~3 byte times of latency: several wait bytes expected
        do_write(8'h8F, 8'h0A, 32'h0BADF00D, 500, 2);
        do_read(8'h0A, 32'h0BADF00D, 500, 2, 8);
    endtask

    task automatic test_abort();
        logic [7:0] rx;
        int t0 = txn_cnt;
        frame_begin();
        spi_byte(8'h8F, rx);
        spi_byte(8'h05, rx);
        spi_byte(8'h99, rx);
        spi_byte(8'h88, rx);
        frame_end();
        check("R8", "no transfer after mid-data abort", 32'(txn_cnt - t0), 32'h0);
        frame_begin();
        spi_byte(8'h0F, rx);
        spi_bits(4);
        frame_end();
        check("R8", "no transfer after mid-byte abort", 32'(txn_cnt - t0), 32'h0);
        frame_begin();
        spi_byte(8'h8F, rx);
        frame_end();
        do_read(8'h05, 32'h1234CCDD, 0, 1, 1);
        check("R8", "clean read follows aborts", 32'(txn_cnt - t0), 32'h1);
    endtask

    initial begin
        #(20 * 190000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #105;
        test_reset();
        rst_n = 1'b1;
        #200;
        test_write_read();
        test_slow_bus();
        test_abort();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule